// File: doc/BRIEF.md
# Lockable Throttle Configuration Registers

This block is a small bank of configuration registers for memory throttling. Each throttle function has two registers: a limit field that the throttling counters consume and a control register whose enable bit turns that function on. Software sets the limit fields first, then the enable bits, and then seals the bank with a one-way lock. Once sealed, every throttle register can still be read but ignores writes. Only a cold reset opens the bank again. A warm reset leaves the seal and all stored settings in place.

A separate enable for the error-signal pulse is kept outside the lock and can be written at any time. The block raises a sticky configuration-error flag if a function is ever enabled while its limit field is zero. When throttling is active and the error-signal enable is set, it emits a one-cycle error pulse on each rising edge of the external throttle-event input.

The lock is a two-state machine. In state `LK_OPEN` the throttle registers are writable. The transition OPEN→SEALED is taken on a write to the lock register with bit 0 set. In state `LK_SEALED` the only transition is the hold SEALED→SEALED, and cold reset alone returns the machine to `LK_OPEN`. Access goes through a simple valid/write/address/data port. A read is answered one cycle later on `rd_valid`/`rd_data`.

Top module: `thr_cfg_regs`

## Requirements
- R1: After cold reset every address reads 0, `locked`, `func_enable`, `func_limit`, `cfg_err`, `err_pulse` and `rd_valid` are 0.
- R2: While open, address 2*i holds the full FIELD_W-bit limit of function i, which reads back as written and drives `func_limit[i*FIELD_W +: FIELD_W]`.
- R3: Address 2*i+1 is the control register of function i. Write-data bit 2 sets its enable, which drives `func_enable[i]`. All other bits, including bits 1:0, read as 0 whatever was written.
- R4: A read request accepted at a clock edge sets `rd_valid` with the addressed register's value after that edge. Unmapped addresses (2*NUM_FUNC+2 and above) read 0, and writes to them change nothing.
- R5: Address 2*NUM_FUNC is the lock register. Writing a 1 in bit 0 moves the lock from OPEN to SEALED. Writing 0 in bit 0 has no effect. Bit 0 reads back the lock state, and the `locked` output follows it.
- R6: While sealed, writes to limit and control registers are ignored and those registers stay readable with their sealed values.
- R7: Address 2*NUM_FUNC+1 bit 0 is the error-signal enable. It is writable and readable in both lock states.
- R8: A warm reset clears `rd_valid` and `err_pulse` but leaves the lock, limits, enables, error-signal enable and `cfg_err` unchanged.
- R9: `cfg_err` becomes 1 one clock after any function is enabled with a zero limit. It then stays 1 until a cold reset.
- R10: `err_pulse` is high for exactly one cycle after an edge at which `throttle_event` rose while at least one function is enabled and the error-signal enable is set. Otherwise it stays 0.
- R11: Once sealed, the lock leaves SEALED only by cold reset, and a cold reset makes the throttle registers writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low asynchronous cold reset, clears everything |
| warm_rst_n | input | 1 | Active-low asynchronous warm reset, clears only the read path and pulse logic |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| throttle_event | input | 1 | External throttle-condition input |
| locked | output | 1 | 1 while the lock machine is in SEALED |
| func_enable | output | NUM_FUNC | Enable bit of each throttle function |
| func_limit | output | NUM_FUNC*FIELD_W | Limit field of each function, packed |
| cfg_err | output | 1 | Sticky configuration-error flag |
| err_pulse | output | 1 | One-cycle error-signal pulse |

## Verification
The bench builds the block with its defaults: two throttle functions, 8-bit limits and data, and a 3-bit address. This makes the register space eight addresses in all, with two of them unmapped. At that size the bench can write every 8-bit value to every limit field and every control register and compare against arithmetic expectations, such as the value masked to bit 2. It can also probe both unmapped addresses directly. The lock, warm-reset and cold-reset sequences are run against known register contents, so writes that are ignored show up on readback.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Lock machine states
    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    // Position of the enable bit inside a control register
    localparam int EN_BIT = 2;

endpackage

// File: rtl/thr_lock_fsm.sv
module thr_lock_fsm (
    input  logic clk,
    input  logic cold_rst_n,
    input  logic lock_wr_i,
    input  logic lock_bit_i,
    output logic sealed_o
);
    import thr_pkg::*;

    lock_state_e state_q;
    lock_state_e state_d;

    // State register: only cold reset reopens
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (lock_wr_i && lock_bit_i) begin
                    state_d = LK_SEALED;
                end
            end
            LK_SEALED: begin
                state_d = LK_SEALED;
            end
        endcase
    end

    // Outputs
    always_comb begin
        sealed_o = 1'b0;
        unique case (state_q)
            LK_OPEN:   sealed_o = 1'b0;
            LK_SEALED: sealed_o = 1'b1;
        endcase
    end

    // R11
    sealed_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    // R5
    open_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        ((state_q == LK_OPEN) && !(lock_wr_i && lock_bit_i)) |=> (state_q == LK_OPEN));

endmodule

// File: rtl/thr_func_regs.sv
module thr_func_regs #(
    parameter int FIELD_W = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               sealed_i,
    input  logic               field_we_i,
    input  logic               ctl_we_i,
    input  logic [FIELD_W-1:0] field_wdata_i,
    input  logic               en_wdata_i,
    output logic [FIELD_W-1:0] limit_o,
    output logic               enable_o,
    output logic [DATA_W-1:0]  field_rd_o,
    output logic [DATA_W-1:0]  ctl_rd_o
);
    import thr_pkg::*;

    logic [FIELD_W-1:0] limit_q;
    logic               enable_q;

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            limit_q  <= '0;
            enable_q <= 1'b0;
        end else if (!sealed_i) begin
            if (field_we_i) begin
                limit_q <= field_wdata_i;
            end
            if (ctl_we_i) begin
                enable_q <= en_wdata_i;
            end
        end
    end

    always_comb begin
        field_rd_o         = DATA_W'(limit_q);
        ctl_rd_o           = '0;
        ctl_rd_o[EN_BIT]   = enable_q;
    end

    assign limit_o  = limit_q;
    assign enable_o = enable_q;

    // R6
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        sealed_i |=> ($stable(limit_q) && $stable(enable_q)));

endmodule

// File: rtl/thr_event_mon.sv
module thr_event_mon #(
    parameter int NUM_FUNC = 2,
    parameter int FIELD_W  = 8
) (
    input  logic                        clk,
    input  logic                        cold_rst_n,
    input  logic                        any_rst_n,
    input  logic [NUM_FUNC-1:0]         enable_i,
    input  logic [NUM_FUNC*FIELD_W-1:0] limits_i,
    input  logic                        serr_en_i,
    input  logic                        event_i,
    output logic                        cfg_err_o,
    output logic                        err_pulse_o
);
    logic [NUM_FUNC-1:0] bad_cfg;
    logic                evt_q;
    logic                any_en;

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_chk
        assign bad_cfg[i] = enable_i[i] && (limits_i[i*FIELD_W +: FIELD_W] == '0);
    end

    assign any_en = |enable_i;

    // Sticky flag survives warm reset
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            cfg_err_o <= 1'b0;
        end else if (|bad_cfg) begin
            cfg_err_o <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) begin
            evt_q       <= 1'b0;
            err_pulse_o <= 1'b0;
        end else begin
            evt_q       <= event_i;
            err_pulse_o <= event_i && !evt_q && any_en && serr_en_i;
        end
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cfg_err_o |=> cfg_err_o);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        err_pulse_o |=> !err_pulse_o);

    // R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        err_pulse_o |-> $past(serr_en_i && event_i));

endmodule

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs #(
    parameter int NUM_FUNC = 2,
    parameter int FIELD_W  = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = $clog2(2*NUM_FUNC + 2)
) (
    input  logic                        clk,
    input  logic                        cold_rst_n,
    input  logic                        warm_rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        throttle_event,
    output logic                        locked,
    output logic [NUM_FUNC-1:0]         func_enable,
    output logic [NUM_FUNC*FIELD_W-1:0] func_limit,
    output logic                        cfg_err,
    output logic                        err_pulse
);
    import thr_pkg::*;

    localparam int LOCK_ADDR = 2*NUM_FUNC;
    localparam int SERR_ADDR = LOCK_ADDR + 1;

    logic                any_rst_n;
    logic                wr_req;
    logic                rd_req;
    logic                sealed;
    logic                serr_en_q;
    logic [NUM_FUNC-1:0] field_we;
    logic [NUM_FUNC-1:0] ctl_we;
    logic [DATA_W-1:0]   field_rd [NUM_FUNC];
    logic [DATA_W-1:0]   ctl_rd   [NUM_FUNC];
    logic [DATA_W-1:0]   rd_mux;

    assign any_rst_n = cold_rst_n & warm_rst_n;
    assign wr_req    = bus_valid &  bus_write;
    assign rd_req    = bus_valid & ~bus_write;

    thr_lock_fsm u_lock (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .lock_wr_i  (wr_req && (bus_addr == ADDR_W'(LOCK_ADDR))),
        .lock_bit_i (bus_wdata[0]),
        .sealed_o   (sealed)
    );

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_func
        assign field_we[i] = wr_req && (bus_addr == ADDR_W'(2*i));
        assign ctl_we[i]   = wr_req && (bus_addr == ADDR_W'(2*i + 1));

        thr_func_regs #(
            .FIELD_W (FIELD_W),
            .DATA_W  (DATA_W)
        ) u_regs (
            .clk           (clk),
            .cold_rst_n    (cold_rst_n),
            .sealed_i      (sealed),
            .field_we_i    (field_we[i]),
            .ctl_we_i      (ctl_we[i]),
            .field_wdata_i (bus_wdata[FIELD_W-1:0]),
            .en_wdata_i    (bus_wdata[EN_BIT]),
            .limit_o       (func_limit[i*FIELD_W +: FIELD_W]),
            .enable_o      (func_enable[i]),
            .field_rd_o    (field_rd[i]),
            .ctl_rd_o      (ctl_rd[i])
        );
    end

    // Error-signal enable: outside the lock, cold reset only
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            serr_en_q <= 1'b0;
        end else if (wr_req && (bus_addr == ADDR_W'(SERR_ADDR))) begin
            serr_en_q <= bus_wdata[0];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (bus_addr == ADDR_W'(2*i)) begin
                rd_mux = field_rd[i];
            end
            if (bus_addr == ADDR_W'(2*i + 1)) begin
                rd_mux = ctl_rd[i];
            end
        end
        if (bus_addr == ADDR_W'(LOCK_ADDR)) begin
            rd_mux = DATA_W'(sealed);
        end
        if (bus_addr == ADDR_W'(SERR_ADDR)) begin
            rd_mux = DATA_W'(serr_en_q);
        end
    end

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= rd_mux;
            end
        end
    end

    thr_event_mon #(
        .NUM_FUNC (NUM_FUNC),
        .FIELD_W  (FIELD_W)
    ) u_mon (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .any_rst_n   (any_rst_n),
        .enable_i    (func_enable),
        .limits_i    (func_limit),
        .serr_en_i   (serr_en_q),
        .event_i     (throttle_event),
        .cfg_err_o   (cfg_err),
        .err_pulse_o (err_pulse)
    );

    assign locked = sealed;

    // R4
    rd_origin_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        rd_valid |-> $past(bus_valid && !bus_write));

    // R7
    serr_write_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (wr_req && (bus_addr == ADDR_W'(SERR_ADDR))) |=> (serr_en_q == $past(bus_wdata[0])));

endmodule

// File: tb/tb_thr_cfg_regs.sv
module tb_thr_cfg_regs;

    localparam int NF  = 2;
    localparam int FW  = 8;
    localparam int DW  = 8;
    localparam int AW  = 3;
    localparam int LOCK_A = 2*NF;
    localparam int SERR_A = LOCK_A + 1;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          warm_rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          throttle_event = 1'b0;
    logic          locked;
    logic [NF-1:0] func_enable;
    logic [NF*FW-1:0] func_limit;
    logic          cfg_err;
    logic          err_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    thr_cfg_regs #(.NUM_FUNC(NF), .FIELD_W(FW), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .throttle_event(throttle_event), .locked(locked),
        .func_enable(func_enable), .func_limit(func_limit),
        .cfg_err(cfg_err), .err_pulse(err_pulse)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = AW'(a); bus_wdata = DW'(d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_valid = 1'b0;
        checks++;
        if (rd_valid !== 1'b1) begin
            errors++;
            $display("FAIL R4 rd_valid actual=%0b expected=1", rd_valid);
        end
        d = int'(rd_data);
    endtask

    task automatic rd_chk(input string req, input int a, input int expected);
        int v;
        rd(a, v);
        check(req, v, expected);
    endtask

    task automatic event_pulse(input string req, input int expected);
        @(negedge clk);
        throttle_event = 1'b1;
        @(negedge clk);
        check(req, int'(err_pulse), expected);
        @(negedge clk);
        check(req, int'(err_pulse), 0);
        throttle_event = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1; warm_rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 locked", int'(locked), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        check("R1 err_pulse", int'(err_pulse), 0);
        check("R1 func_enable", int'(func_enable), 0);
        check("R1 func_limit", int'(func_limit), 0);
        for (int a = 0; a < 8; a++) rd_chk("R1 readback", a, 0);

        // R2 limit sweep
        for (int f = 0; f < NF; f++) begin
            for (int v = 0; v < 256; v++) begin
                wr(2*f, v);
                rd_chk("R2 limit", 2*f, v);
                check("R2 func_limit", int'(func_limit[f*FW +: FW]), v);
            end
        end

        // R3 control sweep (limits are 255)
        for (int f = 0; f < NF; f++) begin
            for (int d = 0; d < 256; d++) begin
                wr(2*f+1, d);
                rd_chk("R3 control", 2*f+1, d & 4);
                check("R3 func_enable", int'(func_enable[f]), (d >> 2) & 1);
            end
        end
        check("R9 no error", int'(cfg_err), 0);

        // R4 unmapped
        for (int a = 2*NF+2; a < 8; a++) begin
            wr(a, 8'hFF);
            rd_chk("R4 unmapped", a, 0);
        end
        rd_chk("R4 limit0 kept", 0, 255);
        rd_chk("R4 lock kept", LOCK_A, 0);
        rd_chk("R4 serr kept", SERR_A, 0);

        // R10 event pulse
        wr(SERR_A, 1);
        rd_chk("R7 serr set", SERR_A, 1);
        event_pulse("R10 pulse", 1);
        wr(SERR_A, 0);
        event_pulse("R10 serr off", 0);
        wr(SERR_A, 1);
        wr(1, 0); wr(3, 0);
        event_pulse("R10 none enabled", 0);
        wr(1, 4); wr(3, 4);
        event_pulse("R10 pulse again", 1);

        // R9 sticky error
        wr(2, 0);
        @(negedge clk);
        check("R9 error raised", int'(cfg_err), 1);
        wr(2, 9);
        @(negedge clk);
        check("R9 error sticky", int'(cfg_err), 1);

        // R5 lock register
        wr(LOCK_A, 0);
        rd_chk("R5 zero no effect", LOCK_A, 0);
        wr(0, 8'h12);
        rd_chk("R5 still open", 0, 8'h12);
        wr(LOCK_A, 8'hFE);
        rd_chk("R5 bit0 clear", LOCK_A, 0);
        wr(LOCK_A, 1);
        rd_chk("R5 sealed", LOCK_A, 1);
        check("R5 locked out", int'(locked), 1);

        // R6 sealed writes ignored
        wr(0, 8'h34);
        rd_chk("R6 limit frozen", 0, 8'h12);
        wr(1, 0);
        rd_chk("R6 control frozen", 1, 4);
        check("R6 enable frozen", int'(func_enable[0]), 1);
        wr(LOCK_A, 0);
        rd_chk("R11 lock held", LOCK_A, 1);

        // R7 serr enable while sealed
        wr(SERR_A, 0);
        rd_chk("R7 serr clear sealed", SERR_A, 0);
        wr(SERR_A, 1);
        rd_chk("R7 serr set sealed", SERR_A, 1);

        // R8 warm reset
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(0);
        @(negedge clk);
        bus_valid = 1'b0;
        warm_rst_n = 1'b0;
        #1;
        check("R8 rd_valid cleared", int'(rd_valid), 0);
        @(negedge clk);
        warm_rst_n = 1'b1;
        check("R8 cfg_err kept", int'(cfg_err), 1);
        check("R8 locked kept", int'(locked), 1);
        rd_chk("R8 limit0 kept", 0, 8'h12);
        rd_chk("R8 limit1 kept", 2, 9);
        rd_chk("R8 ctl1 kept", 3, 4);
        rd_chk("R8 serr kept", SERR_A, 1);
        wr(0, 8'h77);
        rd_chk("R11 warm no unlock", 0, 8'h12);

        // R11 cold reset unlocks
        @(negedge clk);
        cold_rst_n = 1'b0;
        @(negedge clk);
        cold_rst_n = 1'b1;
        rd_chk("R11 lock cleared", LOCK_A, 0);
        rd_chk("R1 limit cleared", 0, 0);
        check("R1 cfg_err cleared", int'(cfg_err), 0);
        wr(0, 8'h77);
        rd_chk("R11 writable", 0, 8'h77);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule